// File: doc/BRIEF.md
# Pulse Width Modulator with Selectable Stop Behaviour

This block generates one pulse width modulated output from a free-running system clock. A down-counting prescaler turns the clock into slower ticks. Each tick advances an up-counter that runs from zero to one past a programmed period value and then wraps. Two comparisons on that count shape the waveform. The match against the duty value drives the output high. The match against the period end drives it low. Software programs three values through simple write strobes that share one data bus: a control word (prescale and stop style), a duty value and a period value.

Duty and period writes go to shadow copies. Those copies move into the working registers only when a cycle starts, or at any time while the unit is idle, so a running cycle never mixes old and new settings. A clock-enable input starts and stops the unit. When it drops, the control word decides the stop style. In abrupt mode the output is forced low at once and the counters freeze where they are. In graceful mode the current cycle runs to its end, and the unit then parks idle with its counters at zero.

Top module: `pwm_gen`

## Requirements
- R1: Reset behaviour:
  - The output is low.
  - Prescale, stop mode and duty clear to 0.
  - Period loads 4.
  - With only a duty of 1 written afterwards, the output is high for 4 clocks in every 6.
- R2: A write with `wr_ctrl` takes its prescale from `wdata[5:0]` and its stop mode from `wdata[6]` (1 = graceful). Every counter tick then lasts prescale+1 clocks.
- R3: The up-counter runs from 0 to period+1 and wraps on the following tick, so one output cycle lasts (period+2) ticks.
- R4: With duty nonzero and period at least duty:
  - The output rises on the tick after the count equals duty.
  - It falls on the tick after the count equals period+1.
  - It stays high for (period+1-duty) ticks.
- R5: A duty value of 0 keeps the output low while the unit runs.
- R6: With duty nonzero and period below duty, the output stays high continuously while the unit runs.
- R7: A duty or period write made while the unit runs leaves the current cycle unchanged. The new value takes effect at the next wrap.
- R8: Abrupt stop (stop mode 0):
  - One clock after the enable drops, the output is low.
  - The counters hold their values.
  - On re-enable, counting resumes from the held count one clock later.
- R9: Graceful stop (stop mode 1): after the enable drops, the current cycle completes with its full high time. The output then stays low and the counters return to 0.
- R10: From idle, with prescale 0, the first rising edge of the output comes duty+2 clocks after the enable rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Run enable; dropping it starts the selected stop behaviour |
| wr_ctrl | input | 1 | Write strobe for the control word (prescale, stop mode) |
| wr_duty | input | 1 | Write strobe for the duty shadow register |
| wr_period | input | 1 | Write strobe for the period shadow register |
| wdata | input | CNT_W | Shared write data for all three strobes |
| pwm_out | output | 1 | Modulated output |

## Verification
Any wrong internal count shows at the port within one output cycle as a shifted edge: a stale duty moves the rising edge, and a wrong wrap point stretches the period. A counter that runs past the period end pins the output high for up to 1024 ticks. The bench therefore measures rise-to-rise intervals and high widths in clocks and compares them against values computed from prescale, duty and period. A frozen count that is lost during an abrupt stop appears as a resume-to-rise delay of duty+2 instead of period+3 clocks. A shadow copy that is bypassed makes the first pulse after a mid-cycle write too long or never end.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

   // Run-control states of the modulator
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,   // parked, counters cleared, shadows pass through
      ST_RUN   = 2'd1,   // counting normally
      ST_DRAIN = 2'd2,   // enable dropped, finishing the current cycle
      ST_HOLD  = 2'd3    // enable dropped abruptly, counters frozen
   } run_state_e;

   // Bit position of the stop-mode flag inside the control word
   localparam int unsigned CTRL_MODE_BIT = 6;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_gen_pkg::*;
#(
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned PSC_W      = 6,
   parameter int unsigned RST_PERIOD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_duty,
   input  logic             wr_period,
   input  logic [CNT_W-1:0] wdata,
   input  logic             load_act,
   output logic [PSC_W-1:0] psc_val,
   output logic             graceful,
   output logic [CNT_W-1:0] duty_act,
   output logic [CNT_W-1:0] per_act
);

   localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(RST_PERIOD);

   generate
      if (CNT_W < PSC_W + 1) begin : g_bad_ctrl_width
         $error("pwm_regs: control word needs PSC_W+1 bits of wdata");
      end
      if (CTRL_MODE_BIT < PSC_W) begin : g_bad_mode_bit
         $error("pwm_regs: mode bit overlaps prescale field");
      end
      if (RST_PERIOD >= (1 << CNT_W)) begin : g_bad_rst_period
         $error("pwm_regs: reset period does not fit the counter");
      end
   endgenerate

   logic [CNT_W-1:0] duty_shd;
   logic [CNT_W-1:0] per_shd;

   // Control word applies immediately
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psc_val  <= '0;
         graceful <= 1'b0;
      end else if (wr_ctrl) begin
         psc_val  <= wdata[PSC_W-1:0];
         graceful <= wdata[CTRL_MODE_BIT];
      end
   end

   // Shadow copies take every write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_shd <= '0;
         per_shd  <= PER_INIT;
      end else begin
         if (wr_duty)   duty_shd <= wdata;
         if (wr_period) per_shd  <= wdata;
      end
   end

   // Working copies change only at a cycle boundary or while idle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_act <= '0;
         per_act  <= PER_INIT;
      end else if (load_act) begin
         duty_act <= duty_shd;
         per_act  <= per_shd;
      end
   end

   // R7: working values never move between boundaries
   a_r7_shadow_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !load_act |=> ($stable(duty_act) && $stable(per_act)));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned PSC_W  = 6,
   parameter bit          USE_PSC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [PSC_W-1:0] psc_val,
   output logic             tick
);

   generate
      if (PSC_W < 1) begin : g_bad_psc_w
         $error("pwm_prescaler: PSC_W must be at least 1");
      end

      if (USE_PSC) begin : g_divider
         logic [PSC_W-1:0] down_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               down_q <= '0;
            end else if (run) begin
               if (down_q == '0) down_q <= psc_val;
               else              down_q <= down_q - 1'b1;
            end
         end

         assign tick = run && (down_q == '0);
      end else begin : g_bypass
         logic unused_psc;
         assign unused_psc = ^{psc_val, clear, rst_n, clk};
         assign tick       = run;
      end
   endgenerate

endmodule

// File: rtl/pwm_cmp_counter.sv
module pwm_cmp_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  logic             force_low,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] per,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             pwm_out
);

   localparam int unsigned EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] end_val;
   logic             at_end;
   logic             at_wrap;
   logic             duty_hit;
   logic             stuck_high;

   assign end_val    = {1'b0, per} + EXT_W'(1);
   assign at_end     = ({1'b0, cnt} == end_val);
   assign at_wrap    = at_end || (cnt == {CNT_W{1'b1}});
   assign duty_hit   = (duty != '0) && (cnt == duty);
   assign stuck_high = (duty != '0) && (per < duty);
   assign wrap       = tick && at_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt     <= '0;
         pwm_out <= 1'b0;
      end else if (force_low) begin
         pwm_out <= 1'b0;
      end else if (tick) begin
         cnt <= at_wrap ? '0 : cnt + 1'b1;
         if (stuck_high)    pwm_out <= 1'b1;
         else if (at_end)   pwm_out <= 1'b0;
         else if (duty_hit) pwm_out <= 1'b1;
      end
   end

   // R3: the count never passes one beyond the working period
   a_r3_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} <= end_val));

   // R5: a zero working duty never raises the output
   a_r5_zero_duty_low : assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |=> !$rose(pwm_out));

endmodule

// File: rtl/pwm_run_ctrl.sv
module pwm_run_ctrl
   import pwm_gen_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clk_en,
   input  logic       graceful,
   input  logic       wrap,
   output logic       run,
   output logic       clear,
   output logic       force_low,
   output run_state_e state
);

   run_state_e state_d;

   always_comb begin
      run       = 1'b0;
      clear     = 1'b0;
      force_low = 1'b0;
      state_d   = state;
      unique case (state)
         ST_IDLE: begin
            clear = 1'b1;
            if (clk_en) state_d = ST_RUN;
         end
         ST_RUN: begin
            if (clk_en) begin
               run = 1'b1;
            end else if (graceful) begin
               run     = 1'b1;
               state_d = wrap ? ST_IDLE : ST_DRAIN;
            end else begin
               force_low = 1'b1;
               state_d   = ST_HOLD;
            end
         end
         ST_DRAIN: begin
            run = 1'b1;
            if (clk_en)    state_d = ST_RUN;
            else if (wrap) state_d = ST_IDLE;
         end
         ST_HOLD: begin
            if (clk_en) state_d = ST_RUN;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_d;
   end

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
   import pwm_gen_pkg::*;
#(
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned PSC_W      = 6,
   parameter int unsigned RST_PERIOD = 4,
   parameter bit          USE_PSC    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             wr_ctrl,
   input  logic             wr_duty,
   input  logic             wr_period,
   input  logic [CNT_W-1:0] wdata,
   output logic             pwm_out
);

   logic [PSC_W-1:0] psc_val;
   logic             graceful;
   logic [CNT_W-1:0] duty_act;
   logic [CNT_W-1:0] per_act;
   logic [CNT_W-1:0] cnt;
   logic             tick;
   logic             wrap;
   logic             run;
   logic             clear;
   logic             force_low;
   logic             load_act;
   run_state_e       state;

   assign load_act = clear || wrap;

   pwm_regs #(
      .CNT_W      (CNT_W),
      .PSC_W      (PSC_W),
      .RST_PERIOD (RST_PERIOD)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .wr_duty   (wr_duty),
      .wr_period (wr_period),
      .wdata     (wdata),
      .load_act  (load_act),
      .psc_val   (psc_val),
      .graceful  (graceful),
      .duty_act  (duty_act),
      .per_act   (per_act)
   );

   pwm_run_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .graceful  (graceful),
      .wrap      (wrap),
      .run       (run),
      .clear     (clear),
      .force_low (force_low),
      .state     (state)
   );

   pwm_prescaler #(
      .PSC_W   (PSC_W),
      .USE_PSC (USE_PSC)
   ) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .clear   (clear),
      .psc_val (psc_val),
      .tick    (tick)
   );

   pwm_cmp_counter #(
      .CNT_W (CNT_W)
   ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .clear     (clear),
      .force_low (force_low),
      .duty      (duty_act),
      .per       (per_act),
      .cnt       (cnt),
      .wrap      (wrap),
      .pwm_out   (pwm_out)
   );

   // R8: abrupt stop pulls the output low on the next clock
   a_r8_abrupt_low : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !clk_en && !graceful) |=> !pwm_out);

   // R8: while frozen the count holds and the output stays low
   a_r8_hold_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !clk_en) |=> ($stable(cnt) && !pwm_out));

   // R9: leaving idle always starts from a zero count with a low output
   a_r9_idle_clean : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> (cnt == '0 && !pwm_out));

endmodule

// File: tb/test_pwm_gen.sv
`timescale 1ns/1ps
module test_pwm_gen;

   localparam int CNT_W = 10;

   logic             clk       = 1'b0;
   logic             rst_n     = 1'b0;
   logic             clk_en    = 1'b0;
   logic             wr_ctrl   = 1'b0;
   logic             wr_duty   = 1'b0;
   logic             wr_period = 1'b0;
   logic [CNT_W-1:0] wdata     = '0;
   logic             pwm_out;

   always #4 clk = ~clk;

   pwm_gen #(.CNT_W(CNT_W)) i_pwm_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .wr_ctrl   (wr_ctrl),
      .wr_duty   (wr_duty),
      .wr_period (wr_period),
      .wdata     (wdata),
      .pwm_out   (pwm_out)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      int    high;
      int    per;
      string req;
   } exp_t;
   exp_t exp_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   // Monitor: measures high width and rise-to-rise interval in clocks
   bit mon_on    = 1'b0;
   bit have_rise = 1'b0;
   bit prev_out  = 1'b0;
   int since_rise = 0;
   int last_high  = 0;
   int fall_cnt   = 0;
   int rise_cnt   = 0;

   always @(negedge clk) begin
      if (!mon_on) begin
         have_rise = 1'b0;
         prev_out  = pwm_out;
      end else begin
         since_rise++;
         if (pwm_out && !prev_out) begin
            rise_cnt++;
            if (have_rise && exp_q.size() > 0) begin
               exp_t e;
               e = exp_q.pop_front();
               chk(last_high == e.high, e.req, last_high, e.high);
               chk(since_rise == e.per, e.req, since_rise, e.per);
            end
            have_rise  = 1'b1;
            since_rise = 0;
         end
         if (!pwm_out && prev_out && have_rise) begin
            last_high = since_rise;
            fall_cnt++;
         end
         prev_out = pwm_out;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      mon_on = 1'b0;
      clk_en = 1'b0;
      rst_n  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
   endtask

   task automatic wr_reg(input int sel, input int val);
      wdata = CNT_W'(val);
      case (sel)
         0:       wr_ctrl   = 1'b1;
         1:       wr_duty   = 1'b1;
         default: wr_period = 1'b1;
      endcase
      @(negedge clk);
      #1;
      wr_ctrl   = 1'b0;
      wr_duty   = 1'b0;
      wr_period = 1'b0;
   endtask

   task automatic wait_rise(input int limit, input string req);
      int s = rise_cnt;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         #1;
         if (rise_cnt != s) return;
      end
      chk(1'b0, req, 0, 1);
   endtask

   task automatic wait_fall(input int limit, input string req);
      int s = fall_cnt;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         #1;
         if (fall_cnt != s) return;
      end
      chk(1'b0, req, 0, 1);
   endtask

   // Clocks from enable (set just after a falling edge) to the first high sample
   task automatic edges_to_rise(input int limit, output int n);
      n = 0;
      clk_en = 1'b1;
      for (int i = 0; i < limit; i++) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (pwm_out) return;
      end
   endtask

   // Scoreboard case: program, enable, push expected pulses, drain queue
   task automatic run_case(input int psc, input int duty, input int per, input bit set_per,
                           input int n, input string req);
      do_reset();
      wr_reg(0, (1 << 6) | psc);
      wr_reg(1, duty);
      if (set_per) wr_reg(2, per);
      mon_on = 1'b1;
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.high = (per + 1 - duty) * (psc + 1);
         e.per  = (per + 2) * (psc + 1);
         e.req  = req;
         exp_q.push_back(e);
      end
      clk_en = 1'b1;
      for (int i = 0; i < 20000 && exp_q.size() > 0; i++) @(negedge clk);
      if (exp_q.size() > 0) begin
         chk(1'b0, req, exp_q.size(), 0);
         exp_q.delete();
      end
      clk_en = 1'b0;
      mon_on = 1'b0;
   endtask

   initial begin
      int n;
      int highs;
      int lows;
      int s;

      // R1: output low during and right after reset
      repeat (2) @(negedge clk);
      chk(pwm_out == 1'b0, "R1 during reset", pwm_out, 0);
      do_reset();
      chk(pwm_out == 1'b0, "R1 after reset", pwm_out, 0);

      // R5: running with the reset duty of 0 never raises the output
      clk_en = 1'b1;
      highs  = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      chk(highs == 0, "R5 zero duty", highs, 0);
      clk_en = 1'b0;

      // R1: reset period 4 with duty 1 -> high 4 of 6 clocks
      run_case(0, 1, 4, 1'b0, 3, "R1 default period");
      // R3 R4: basic waveform
      run_case(0, 3, 9, 1'b1, 3, "R3 R4 basic");
      // R4: smallest duty and period
      run_case(0, 1, 1, 1'b1, 3, "R4 minimal");
      // R2: prescale stretches each tick
      run_case(3, 2, 5, 1'b1, 2, "R2 prescale 3");
      run_case(2, 7, 7, 1'b1, 2, "R2 R4 duty equals period");

      // R6: period below duty holds the output high
      do_reset();
      wr_reg(1, 10);
      wr_reg(2, 4);
      clk_en = 1'b1;
      repeat (20) @(negedge clk);
      lows = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!pwm_out) lows++;
      end
      chk(lows == 0, "R6 stuck high", lows, 0);
      clk_en = 1'b0;

      // R7: shrinking the period mid-pulse does not cut the current cycle
      do_reset();
      wr_reg(0, 1 << 6);
      wr_reg(1, 5);
      wr_reg(2, 20);
      mon_on = 1'b1;
      clk_en = 1'b1;
      wait_rise(200, "R7 first rise");
      repeat (2) @(negedge clk);
      #1;
      wr_reg(2, 6);
      wait_fall(3000, "R7 fall");
      chk(last_high == 16, "R7 old period kept", last_high, 16);
      wait_fall(3000, "R7 next fall");
      chk(last_high == 2, "R7 new period used", last_high, 2);
      clk_en = 1'b0;
      mon_on = 1'b0;

      // R8: abrupt stop right after a rising edge, then resume
      do_reset();
      wr_reg(0, 0);
      wr_reg(1, 3);
      wr_reg(2, 40);
      mon_on = 1'b1;
      clk_en = 1'b1;
      wait_rise(200, "R8 first rise");
      clk_en = 1'b0;
      @(negedge clk);
      chk(pwm_out == 1'b0, "R8 low after stop", pwm_out, 0);
      highs = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      chk(highs == 0, "R8 stays low", highs, 0);
      #1;
      edges_to_rise(500, n);
      chk(n == 43, "R8 resume from held count", n, 43);
      clk_en = 1'b0;
      mon_on = 1'b0;

      // R9: graceful stop finishes the pulse, then R10 restart from zero
      do_reset();
      wr_reg(0, 1 << 6);
      wr_reg(1, 3);
      wr_reg(2, 40);
      mon_on = 1'b1;
      clk_en = 1'b1;
      wait_rise(200, "R9 first rise");
      repeat (5) @(negedge clk);
      #1;
      clk_en = 1'b0;
      wait_fall(200, "R9 fall");
      chk(last_high == 38, "R9 full pulse", last_high, 38);
      s     = rise_cnt;
      highs = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      chk(highs == 0 && rise_cnt == s, "R9 stays low", highs, 0);
      #1;
      edges_to_rise(500, n);
      chk(n == 5, "R10 restart from zero", n, 5);
      clk_en = 1'b0;
      mon_on = 1'b0;

      // R10: first start out of reset with a larger duty
      do_reset();
      wr_reg(1, 9);
      wr_reg(2, 30);
      edges_to_rise(500, n);
      chk(n == 11, "R10 first start", n, 11);
      clk_en = 1'b0;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule